// File: doc/BRIEF.md
# Two-Strike Watchdog Timer

This block is a system watchdog that tolerates one missed service before it acts. A down-counter advances on a one-cycle prescaler tick and is restarted from a programmable timeout by a reload strobe. The first time it runs out, it only raises a sticky expired flag in a status register. If the counter runs out a second time while that flag is still set, the block emits a single-cycle reboot pulse. The hang time before a reboot is therefore between roughly one and two timeout periods, depending on where in the period the system stalled.

Software services the timer by pulsing the reload strobe and by writing a one to the flag bit of the status register. The reload alone does not clear the flag. A second register holds a firmware-clear enable. While it is set, firmware takes the flag back down on the tick after each expiry, so the block can never reboot the system. This enable comes out of reset set, and software has to turn it off before the watchdog can take effect.

Top module: `strike2_wdog`

## Requirements
- R1: After reset the status register (offset 0x64) reads 0, the firmware-clear register (offset 0x30) reads 0x2000, and `reboot_o` is low.
- R2: After a reload with timeout T of at least 1, the T-th tick that follows is an expiry. An expiry with the flag clear sets the flag, and the status register reads 0x8 (bit 3) from the next cycle on.
- R3: An expiry that finds the flag set, with firmware clearing disabled, drives `reboot_o` high for exactly one cycle, starting in the cycle after the edge that took the expiring tick.
- R4: The same edge returns the flag to 0 and the counter to 0, so the next tick is an expiry.
- R5: Writing the status register with bit 3 set clears the flag from the next cycle on. A later expiry then only sets the flag again and does not reboot.
- R6: Writing the status register with bit 3 clear leaves the flag unchanged, whatever the other bits hold.
- R7: Only bit 13 of the firmware-clear register is stored; all other bits read 0. While bit 13 is 1, `reboot_o` stays low. A set flag is cleared on the next tick that is not itself an expiry, and it holds its value in cycles without a tick.
- R8: The reload strobe loads the counter from `timeout_i` and leaves the flag unchanged. A reload in the same cycle as a tick wins: the tick neither counts nor expires.
- R9: A timeout of 0 acts as 1, so every tick is an expiry.
- R10: When a flag-clearing status write and an expiry fall in the same cycle, the clear applies first. The flag ends up set and no reboot is issued.
- R11: Writes to any offset other than 0x30 and 0x64 are ignored, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base pulse from the prescaler |
| kick_i | input | 1 | Reload strobe |
| timeout_i | input | CNT_W | Timeout in ticks |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register offset for writes and reads |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` (combinational) |
| reboot_o | output | 1 | Single-cycle reboot pulse |

## Verification
The assertions check several properties on every cycle:
- The reboot pulse lasts one cycle, needs a set flag and a tick just before it, and never appears while firmware clearing is enabled.
- The flag and the counter are at zero during the pulse.
- A reload lands the timeout value in the counter.
- A clearing write without a tick drops the flag.
- The flag only rises on a tick.

Some behaviours can only be shown by the bench's scenarios, because they depend on exact tick counts:
- the number of ticks before an expiry;
- a tick that a simultaneous reload cancels;
- the zero-timeout case;
- the ordering when a clear and an expiry meet;
- the tick-delayed firmware clear;
- register decoding and the masking of readback bits.

// File: rtl/strike2_pkg.sv
package strike2_pkg;
  // Bit positions that software depends on
  localparam int unsigned FLAG_BIT    = 3;
  localparam int unsigned SMI_CLR_BIT = 13;
  // Default register offsets
  localparam logic [7:0] SMI_OFS_DEF  = 8'h30;
  localparam logic [7:0] STAT_OFS_DEF = 8'h64;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SMI  = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/strike2_regs.sv
module strike2_regs
  import strike2_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] SMI_OFS  = ADDR_W'(SMI_OFS_DEF),
  parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(STAT_OFS_DEF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              flag_i,
  output logic              smi_clr_en_o,
  output logic              flag_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e sel;
  logic     smi_q, smi_d, smi_we;
  logic     unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_comb begin
    sel = SEL_NONE;
    if (addr_i == SMI_OFS)       sel = SEL_SMI;
    else if (addr_i == STAT_OFS) sel = SEL_STAT;
  end

  // Next state of the firmware-clear enable
  always_comb begin
    smi_we = wr_i && (sel == SEL_SMI);
    smi_d  = wdata_i[SMI_CLR_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     smi_q <= 1'b1;
    else if (smi_we) smi_q <= smi_d;
  end

  assign smi_clr_en_o = smi_q;
  assign flag_clr_o   = wr_i && (sel == SEL_STAT) && wdata_i[FLAG_BIT];

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_SMI:  rdata_o[SMI_CLR_BIT] = smi_q;
      SEL_STAT: rdata_o[FLAG_BIT]    = flag_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/strike2_count.sv
module strike2_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             at_end, cnt_en;

  assign at_end   = (count_q <= CNT_W'(1));
  assign expire_o = tick_i && !kick_i && at_end;

  always_comb begin
    count_d = count_q;
    cnt_en  = restart_i || kick_i || tick_i;
    if (restart_i)   count_d = '0;
    else if (kick_i) count_d = load_i;
    else if (tick_i) count_d = at_end ? load_i : (count_q - CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/strike2_flag.sv
module strike2_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic expire_i,
  input  logic smi_clr_en_i,
  input  logic flag_clr_i,
  output logic flag_o,
  output logic reboot_now_o,
  output logic reboot_o
);
  logic flag_q, flag_d, flag_eff, fire;
  logic reboot_q;

  always_comb begin
    flag_eff = flag_q && !flag_clr_i;  // software clear applies first
    fire     = 1'b0;
    flag_d   = flag_eff;
    if (expire_i) begin
      if (flag_eff && !smi_clr_en_i) begin
        fire   = 1'b1;
        flag_d = 1'b0;
      end else begin
        flag_d = 1'b1;
      end
    end else if (tick_i && flag_eff && smi_clr_en_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= 1'b0;
      reboot_q <= 1'b0;
    end else begin
      flag_q   <= flag_d;
      reboot_q <= fire;
    end
  end

  assign flag_o       = flag_q;
  assign reboot_now_o = fire;
  assign reboot_o     = reboot_q;
endmodule

// File: rtl/strike2_wdog.sv
module strike2_wdog
  import strike2_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] SMI_OFS  = ADDR_W'(SMI_OFS_DEF),
  parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(STAT_OFS_DEF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              kick_i,
  input  logic [CNT_W-1:0]  timeout_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reboot_o
);
  logic             flag_q, smi_clr_en, flag_clr;
  logic             expire, reboot_now;
  logic [CNT_W-1:0] count_q;
  logic             unused_count;

  assign unused_count = ^count_q;

  strike2_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SMI_OFS(SMI_OFS), .STAT_OFS(STAT_OFS)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .flag_i(flag_q), .smi_clr_en_o(smi_clr_en),
    .flag_clr_o(flag_clr), .rdata_o(reg_rdata_o)
  );

  strike2_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .kick_i(kick_i),
    .restart_i(reboot_now), .load_i(timeout_i), .expire_o(expire),
    .count_o(count_q)
  );

  strike2_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .expire_i(expire),
    .smi_clr_en_i(smi_clr_en), .flag_clr_i(flag_clr), .flag_o(flag_q),
    .reboot_now_o(reboot_now), .reboot_o(reboot_o)
  );
endmodule

// File: rtl/strike2_chk.sv
module strike2_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             kick_i,
  input logic [CNT_W-1:0] timeout_i,
  input logic             reboot_o,
  input logic             flag_i,
  input logic             smi_en_i,
  input logic [CNT_W-1:0] count_i,
  input logic             clr_i
);
  a_r3_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_o |=> !reboot_o);

  a_r3_second_strike: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reboot_o) |-> ($past(flag_i) && $past(tick_i)));

  a_r7_no_reboot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_en_i |=> !reboot_o);

  a_r4_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_o |-> (!flag_i && count_i == '0));

  a_r8_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (count_i == $past(timeout_i)));

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !tick_i) |=> !flag_i);

  a_r2_flag_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(tick_i));
endmodule

bind strike2_wdog strike2_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .kick_i(kick_i),
  .timeout_i(timeout_i), .reboot_o(reboot_o), .flag_i(flag_q),
  .smi_en_i(smi_clr_en), .count_i(count_q), .clr_i(flag_clr)
);

// File: tb/sim_strike2_wdog.sv
module sim_strike2_wdog;
  localparam logic [7:0] SMI  = 8'h30;
  localparam logic [7:0] STAT = 8'h64;
  localparam logic [7:0] HOLE = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, kick, wr;
  logic [7:0]  timeout, addr;
  logic [31:0] wdata, rdata;
  logic        reboot;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0]  a;
    logic [31:0] rd;
    logic        rb;
    int          req;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;  // 250 MHz

  strike2_wdog u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .kick_i(kick),
    .timeout_i(timeout), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reboot_o(reboot)
  );

  // Monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (rdata !== it.rd || reboot !== it.rb) begin
          fails++;
          $display("FAIL R%0d addr=%h rdata=%h exp=%h reboot=%b exp=%b",
                   it.req, it.a, rdata, it.rd, reboot, it.rb);
        end
      end
    end
  end

  // Driver: one clock step, then queue the expected result
  task automatic step(input logic tk, input logic kk, input logic w,
                      input logic [7:0] a, input logic [31:0] wd,
                      input logic [7:0] ra, input logic [31:0] er,
                      input logic erb, input int req);
    item_t it;
    tick = tk; kick = kk; wr = w; addr = a; wdata = wd;
    @(posedge clk); #1;
    tick = 1'b0; kick = 1'b0; wr = 1'b0; addr = ra; wdata = '0;
    it.a = ra; it.rd = er; it.rb = erb; it.req = req;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  function automatic logic [31:0] st(input logic f);
    return f ? 32'h8 : 32'h0;
  endfunction

  task automatic do_tick(input logic f, input logic rb, input int req);
    step(1'b1, 1'b0, 1'b0, STAT, '0, STAT, st(f), rb, req);
  endtask
  task automatic do_kick(input logic tk, input logic f, input int req);
    step(tk, 1'b1, 1'b0, STAT, '0, STAT, st(f), 1'b0, req);
  endtask
  task automatic do_wr(input logic [7:0] a, input logic [31:0] wd,
                       input logic f, input int req);
    step(1'b0, 1'b0, 1'b1, a, wd, STAT, st(f), 1'b0, req);
  endtask
  task automatic peek(input logic [7:0] a, input logic [31:0] er,
                      input int req);
    step(1'b0, 1'b0, 1'b0, a, '0, a, er, 1'b0, req);
  endtask

  initial begin
    rst_n = 1'b0; tick = 0; kick = 0; wr = 0; addr = STAT; wdata = '0;
    timeout = 8'd3;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;

    peek(STAT, 32'h0, 1);         // R1 flag clear
    peek(SMI, 32'h2000, 1);       // R1 firmware clear on
    do_wr(SMI, 32'h0, 0, 7);      // R7 disable firmware clear
    peek(SMI, 32'h0, 7);          // R7
    do_wr(SMI, 32'hFFFF_FFFF, 0, 7);
    peek(SMI, 32'h2000, 7);       // R7 only bit 13 kept
    do_wr(SMI, 32'hFFFF_DFFF, 0, 7);
    peek(SMI, 32'h0, 7);          // R7

    do_kick(0, 0, 8);             // R8 reload to 3
    do_tick(0, 0, 2);             // R2
    do_tick(0, 0, 2);             // R2
    do_tick(1, 0, 2);             // R2 third tick expires
    do_wr(STAT, 32'h0, 1, 6);     // R6
    do_wr(STAT, 32'hFFFF_FFF7, 1, 6); // R6
    do_kick(0, 1, 8);             // R8 flag survives reload
    do_tick(1, 0, 3);             // R3
    do_tick(1, 0, 3);             // R3
    do_tick(0, 1, 3);             // R3 second strike, R4 flag cleared
    peek(STAT, 32'h0, 3);         // R3 pulse lasts one cycle
    do_tick(1, 0, 4);             // R4 counter was zero

    do_wr(STAT, 32'h8, 0, 5);     // R5 clear
    do_tick(0, 0, 5);
    do_tick(0, 0, 5);
    do_tick(1, 0, 5);             // R5 first strike again, no reboot

    do_kick(1, 1, 8);             // R8 reload beats tick
    do_tick(1, 0, 8);
    do_tick(1, 0, 8);             // R8 would reboot here if tick had counted
    do_tick(0, 1, 3);             // R3

    timeout = 8'd0;
    do_tick(1, 0, 9);             // R9
    do_tick(0, 1, 9);             // R9 zero timeout expires every tick

    do_tick(1, 0, 10);
    step(1'b1, 1'b0, 1'b1, STAT, 32'h8, STAT, 32'h8, 1'b0, 10); // R10
    peek(STAT, 32'h8, 10);        // R10

    timeout = 8'd2;
    do_wr(SMI, 32'h2000, 1, 7);   // R7 enable firmware clear
    do_tick(1, 0, 7);             // R7 expiry with flag set: no reboot
    peek(STAT, 32'h8, 7);         // R7 no clear without a tick
    do_tick(0, 0, 7);             // R7 cleared on following tick
    do_tick(1, 0, 7);             // R7 expiry
    do_tick(0, 0, 7);             // R7

    do_wr(HOLE, 32'hFFFF_FFFF, 0, 11); // R11
    peek(HOLE, 32'h0, 11);        // R11
    peek(SMI, 32'h2000, 11);      // R11 no side effect

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule